// File: doc/BRIEF.md
# Self-Correcting State Register for a Control Sequencer

This block is a small control sequencer whose state register stores a 2-bit binary state code together with extended Hamming check bits. The stored word is decoded every cycle before anything else uses it. A single flipped bit anywhere in the word, whether in a data bit or a check bit, is repaired in the same cycle, so the next-state logic and the outputs always work from the true current state. The machine is not sent to a fallback state.

A word with two flipped bits cannot be repaired. In that case the block raises a sticky error flag and returns the machine to its idle state. The next state is re-encoded with fresh check bits on every clock edge, so a repaired upset does not stay in storage. Test inputs XOR a chosen mask into the word as it is written, which lets a bench upset any bit or pair of bits.

Top module: `hfsm_top`

## Requirements
- R1: While `rst_ni` is low (asynchronous), the machine is in IDLE, `seq_o` = 4'b0001, and `sec_o` and `ded_o` are 0.
- R2: `seq_o` is one-hot, with bit n set in state n (IDLE=0, LOAD=1, RUN=2, DONE=3). Transitions happen on the rising clock edge: IDLE goes to LOAD when `ctrl_i[0]`=1 and otherwise stays; LOAD goes to RUN; RUN stays while `ctrl_i[1]`=1 and otherwise goes to DONE; DONE goes to IDLE.
- R3: The stored word is 6 bits wide. Bit n of `inj_mask_i` flips bit n of the word written at the edge where `inj_en_i`=1. The reset word is all zeros.
- R4: If exactly one bit of the stored word is wrong, whichever of the 6 it is, `seq_o` and the next state are the same as in the error-free machine.
- R5: `sec_o` is 1 exactly in the cycle that holds a word with a single wrong bit, and 0 otherwise.
- R6: If two bits of the stored word are wrong, `sec_o` is 0 in that cycle. On the next edge the machine enters IDLE and `ded_o` becomes 1.
- R7: Once `ded_o` is 1 it stays 1 until reset, even while error-free operation continues.
- R8: The word written at every edge carries freshly computed check bits. A cycle that follows an edge with no injection therefore shows `sec_o`=0, and it raises no new double error.
- R9: When `inj_en_i`=0, `inj_mask_i` has no effect on `seq_o`, `sec_o` or `ded_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 2 | Bit 0 starts the sequence; bit 1 holds the machine in RUN |
| inj_en_i | input | 1 | Enables the XOR of the upset mask into the word being written |
| inj_mask_i | input | 6 | Upset mask, one bit per stored word bit |
| seq_o | output | 4 | One-hot current-state outputs |
| sec_o | output | 1 | Single error corrected in this cycle |
| ded_o | output | 1 | Sticky flag for an uncorrectable double error |

## Verification
An upset applied at an edge lands in the word stored at that edge. Its effect is therefore visible in the following cycle, on `sec_o` and on the repaired `seq_o`, and `ded_o` rises one edge later again, together with the forced return to IDLE. The bench keeps a behavioural reference sequencer that is advanced with the same control inputs. The bench also holds a small expectation pipeline that carries each mask's popcount forward by one cycle, and the double-error flag forward by a second cycle. All outputs are compared on the falling edge of every cycle. In the cycle that holds a double error, the one-hot output is left unchecked, since R6 does not define it for that cycle.

// File: rtl/hfsm_pkg.sv
`timescale 1ns/1ps
package hfsm_pkg;
  localparam int unsigned STATE_W = 2;
  localparam int unsigned NUM_ST  = 1 << STATE_W;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  function automatic bit is_pow2(input int unsigned p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // smallest r with 2^r >= k + r + 1
  function automatic int unsigned chk_bits(input int unsigned k);
    int unsigned r;
    r = 1;
    while ((1 << r) < (k + r + 1)) r++;
    return r;
  endfunction

  // codeword position (1-based) of data bit i: i-th non-power-of-two slot
  function automatic int unsigned data_pos(input int unsigned i);
    int unsigned n, p;
    bit found;
    n = 0; p = 0; found = 1'b0;
    for (int unsigned q = 3; q < 64; q++) begin
      if (!found && !is_pow2(q)) begin
        if (n == i) begin
          p = q;
          found = 1'b1;
        end
        n++;
      end
    end
    return p;
  endfunction

  localparam int unsigned CODE_W = STATE_W + chk_bits(STATE_W) + 1;
endpackage

// File: rtl/secded_enc.sv
`timescale 1ns/1ps
module secded_enc
  import hfsm_pkg::*;
#(
  parameter int unsigned K = STATE_W
) (
  input  logic [K-1:0]                   data_i,
  output logic [K+chk_bits(K):0]         code_o
);
  localparam int unsigned R = chk_bits(K);
  localparam int unsigned N = K + R;

  logic [N:0] cw;
  logic       par;

  // bit 0 is overall parity; 1..N is a plain Hamming codeword
  always_comb begin
    cw = '0;
    for (int i = 0; i < K; i++) cw[data_pos(i)] = data_i[i];
    for (int j = 0; j < R; j++) begin
      par = 1'b0;
      for (int q = 1; q <= N; q++)
        if ((((q >> j) & 1) != 0) && !is_pow2(q)) par = par ^ cw[q];
      cw[1 << j] = par;
    end
    cw[0] = ^cw[N:1];
  end

  assign code_o = cw;
endmodule

// File: rtl/secded_dec.sv
`timescale 1ns/1ps
module secded_dec
  import hfsm_pkg::*;
#(
  parameter int unsigned K = STATE_W
) (
  input  logic [K+chk_bits(K):0] code_i,
  output logic [K-1:0]           data_o,
  output logic                   sec_o,
  output logic                   ded_o
);
  localparam int unsigned R = chk_bits(K);
  localparam int unsigned N = K + R;

  logic [R-1:0] syn;
  logic         odd;
  logic         hit;
  logic [N:0]   fixed;

  always_comb begin
    syn = '0;
    for (int j = 0; j < R; j++)
      for (int q = 1; q <= N; q++)
        if (((q >> j) & 1) != 0) syn[j] = syn[j] ^ code_i[q];
    odd   = ^code_i;
    fixed = code_i;
    hit   = 1'b0;
    sec_o = 1'b0;
    ded_o = 1'b0;
    if (odd) begin
      if (syn == '0) begin
        fixed[0] = ~fixed[0];
        hit      = 1'b1;
      end else begin
        for (int q = 1; q <= N; q++)
          if (int'(syn) == q) begin
            fixed[q] = ~fixed[q];
            hit      = 1'b1;
          end
      end
      // odd parity with a syndrome past the word: more than one upset
      sec_o = hit;
      ded_o = !hit;
    end else if (syn != '0) begin
      ded_o = 1'b1;
    end
    for (int i = 0; i < K; i++) data_o[i] = fixed[data_pos(i)];
  end
endmodule

// File: rtl/seq_core.sv
`timescale 1ns/1ps
module seq_core
  import hfsm_pkg::*;
(
  input  seq_state_e        state_i,
  input  logic [1:0]        ctrl_i,
  output seq_state_e        next_o,
  output logic [NUM_ST-1:0] out_o
);
  always_comb begin
    unique case (state_i)
      ST_IDLE: next_o = ctrl_i[0] ? ST_LOAD : ST_IDLE;
      ST_LOAD: next_o = ST_RUN;
      ST_RUN:  next_o = ctrl_i[1] ? ST_RUN : ST_DONE;
      ST_DONE: next_o = ST_IDLE;
      default: next_o = ST_IDLE;
    endcase
  end

  for (genvar g = 0; g < NUM_ST; g++) begin : g_out
    assign out_o[g] = (STATE_W'(state_i) == STATE_W'(g));
  end
endmodule

// File: rtl/hfsm_top.sv
`timescale 1ns/1ps
module hfsm_top
  import hfsm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        ctrl_i,
  input  logic              inj_en_i,
  input  logic [CODE_W-1:0] inj_mask_i,
  output logic [NUM_ST-1:0] seq_o,
  output logic              sec_o,
  output logic              ded_o
);
  // encoding of ST_IDLE (all-zero data) is the all-zero word
  localparam logic [CODE_W-1:0] RST_WORD = '0;

  logic [CODE_W-1:0]  word_q, word_d, code_w;
  logic [STATE_W-1:0] cur_bits;
  seq_state_e         cur_st, nxt_st, wr_st;
  logic               sec_w, ded_w, ded_q;

  secded_dec #(.K(STATE_W)) u_dec (
    .code_i (word_q),
    .data_o (cur_bits),
    .sec_o  (sec_w),
    .ded_o  (ded_w)
  );

  assign cur_st = seq_state_e'(cur_bits);

  seq_core u_core (
    .state_i (cur_st),
    .ctrl_i  (ctrl_i),
    .next_o  (nxt_st),
    .out_o   (seq_o)
  );

  assign wr_st = ded_w ? ST_IDLE : nxt_st;

  secded_enc #(.K(STATE_W)) u_enc (
    .data_i (wr_st),
    .code_o (code_w)
  );

  assign word_d = code_w ^ (inj_en_i ? inj_mask_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= RST_WORD;
      ded_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      ded_q  <= ded_q | ded_w;
    end
  end

  assign sec_o = sec_w;
  assign ded_o = ded_q;

  // R2
  onehot_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seq_o) == 1);
  // R5
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_w && ded_w));
  // R6
  ded_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ded_w && !inj_en_i) |=> (cur_st == ST_IDLE) && ded_o);
  // R7
  ded_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ded_o |=> ded_o);
  // R8
  clean_rewrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_en_i |=> !sec_w && !ded_w);
endmodule

// File: tb/test_hfsm_top.sv
`timescale 1ns/1ps
module test_hfsm_top;
  import hfsm_pkg::*;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        ctrl_i = '0;
  logic              inj_en_i = 1'b0;
  logic [CODE_W-1:0] inj_mask_i = '0;
  logic [NUM_ST-1:0] seq_o;
  logic              sec_o, ded_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int m_st  = 0;
  bit m_sec = 0;
  bit m_dbl = 0;
  bit m_ded = 0;

  hfsm_top i_hfsm_top (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int golden(input int st, input logic [1:0] c);
    case (st)
      0: return c[0] ? 1 : 0;
      1: return 2;
      2: return c[1] ? 2 : 3;
      default: return 0;
    endcase
  endfunction

  // called at a falling edge: check this cycle, drive, advance one cycle
  task automatic step(input logic [1:0] c, input logic en, input logic [CODE_W-1:0] m);
    int ones;
    if (!m_dbl) chk(m_sec ? "R4 seq" : "R2 seq", int'(seq_o), 1 << m_st);
    chk(m_sec ? "R5 sec" : "R8 sec", int'(sec_o), int'(m_sec && !m_dbl));
    chk(m_ded ? "R7 ded" : "R6 ded", int'(ded_o), int'(m_ded));
    ctrl_i = c;
    inj_en_i = en;
    inj_mask_i = m;
    ones = en ? $countones(m) : 0;
    m_st  = m_dbl ? 0 : golden(m_st, c);
    m_ded = m_ded | m_dbl;
    m_sec = (ones == 1);
    m_dbl = (ones == 2);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    ctrl_i = '0;
    inj_en_i = 1'b0;
    inj_mask_i = '0;
    #1;
    chk("R1 seq", int'(seq_o), 1);
    chk("R1 sec", int'(sec_o), 0);
    chk("R1 ded", int'(ded_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_st = 0; m_sec = 0; m_dbl = 0; m_ded = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    do_reset();
    // clean operation, R2
    for (int i = 0; i < 100; i++) step(2'($urandom), 1'b0, '0);
    // single upsets on every bit, R3 R4 R5
    for (int i = 0; i < 300; i++)
      step(2'($urandom), 1'b1, CODE_W'(1) << (i % CODE_W));
    // injection with mixed quiet cycles, R8
    for (int i = 0; i < 100; i++)
      step(2'($urandom), i[0], CODE_W'(1) << ($urandom % CODE_W));
    // mask ignored while disabled, R9
    for (int i = 0; i < 60; i++) step(2'($urandom), 1'b0, CODE_W'($urandom));
    // every double upset pair, R6 R7
    for (int a = 0; a < CODE_W; a++)
      for (int b = a + 1; b < CODE_W; b++) begin
        do_reset();
        for (int i = 0; i < 2 + (a + b) % 3; i++) step(2'b01, 1'b0, '0);
        step(2'($urandom), 1'b1, (CODE_W'(1) << a) | (CODE_W'(1) << b));
        for (int i = 0; i < 12; i++)
          step(2'($urandom), i[1], CODE_W'(1) << ($urandom % CODE_W));
      end
    do_reset();
    for (int i = 0; i < 20; i++) step(2'($urandom), 1'b0, '0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule